// File: doc/BRIEF.md
# Wide Add/Subtract Unit with Two Flag Groups

This unit adds or subtracts two 256-bit operands. It keeps two independent banks of arithmetic flags. Each bank holds carry, MSb, LSb and zero. Every operation names the bank it updates. The two carry-using operations also take their incoming carry or borrow from that same bank. This lets two multi-word arithmetic chains run interleaved without disturbing each other.

The truncated 256-bit result is registered and appears one cycle after the operation is strobed, marked by a one-cycle valid pulse. The flags are also exposed as a 32-bit control register that software can read and overwrite. In that register the eight flags sit in the low byte and every other bit reads as zero.

Top module: `mfx_wide_adder`

## Requirements
- R1: After reset, `result_o` is zero, `res_valid_o` is low and all eight flags read zero.
- R2: Op code 0 (add) yields `(a + b) mod 2^256` in the cycle after `valid_i`. The selected bank's carry is set exactly when the true sum exceeds 256 bits.
- R3: Op code 1 (add with carry) adds the selected bank's current carry flag as the carry-in.
- R4: Op code 2 (subtract) yields `(a - b) mod 2^256`. The selected bank's carry flag is set exactly when a borrow occurred, which is when `a < b`.
- R5: Op code 3 (subtract with borrow) yields `(a - b - c) mod 2^256`, where c is the selected bank's carry flag. The carry flag is set when `a < b + c`.
- R6: The MSb flag equals bit 255 of the 256-bit result and the LSb flag equals bit 0. The zero flag is set when those 256 bits are all zero, even if a carry out occurred.
- R7: `grp_i` selects bank 0 (value 0) or bank 1 (value 1). The bank that is not selected keeps its value.
- R8: `csr_rdata_o` carries bank 0 in bits 3:0 and bank 1 in bits 7:4. Within each nibble, the order from low bit to high bit is carry, MSb, LSb, zero. Bits 31:8 read zero.
- R9: A write with `csr_we_i` loads all eight flags from `csr_wdata_i[7:0]`, visible on the next cycle. Bits 31:8 of the write data are discarded.
- R10: When `csr_we_i` and `valid_i` are high in the same cycle, the flags take the written value. The result is still produced normally.
- R11: `res_valid_o` is high for exactly the cycle after each `valid_i` cycle. `result_o` holds its value while no operation is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| grp_i | input | 1 | Flag bank to use and update |
| a_i | input | 256 | First operand |
| b_i | input | 256 | Second operand |
| csr_we_i | input | 1 | Flag register write enable |
| csr_wdata_i | input | 32 | Flag register write data |
| csr_rdata_o | output | 32 | Flag register read value |
| result_o | output | 256 | Registered result |
| res_valid_o | output | 1 | Result valid pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the upper register bits reading zero;
- the register write overriding a concurrent update;
- the idle bank staying untouched;
- the MSb, LSb and zero flags of the updated bank agreeing with the registered result;
- the valid pulse and result hold.

Other properties only the bench scenarios can show, because they depend on arithmetic against an independent model:
- the numeric result;
- carry and borrow;
- chained carry-in taken from the right bank.

These are covered by directed corner cases (wrap to zero, borrow, carry-in of one) and by a long run of mixed random operations.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUB  = 2'd2,
    OP_SUBB = 2'd3
  } op_e;

  localparam int unsigned FLAG_N = 4;

  // packed low to high: c, m, l, z (register layout depends on this)
  typedef struct packed {
    logic z;
    logic l;
    logic m;
    logic c;
  } flag_t;
endpackage

// File: rtl/mfx_addsub.sv
module mfx_addsub
  import mfx_pkg::*;
#(
  parameter int unsigned DW = 256
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  op_e           op_i,
  input  logic          cflag_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o
);
  logic          is_sub;
  logic          use_c;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   full;

  always_comb begin
    is_sub  = (op_i == OP_SUB) || (op_i == OP_SUBB);
    use_c   = (op_i == OP_ADDC) || (op_i == OP_SUBB);
    b_eff   = is_sub ? ~b_i : b_i;
    // subtraction as a + ~b + ~borrow_in
    cin     = is_sub ? ~(use_c & cflag_i) : (use_c & cflag_i);
    full    = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    sum_o   = full[DW-1:0];
    carry_o = is_sub ? ~full[DW] : full[DW];
  end
endmodule

// File: rtl/mfx_flag_calc.sv
module mfx_flag_calc
  import mfx_pkg::*;
#(
  parameter int unsigned DW = 256
) (
  input  logic [DW-1:0] sum_i,
  input  logic          carry_i,
  output flag_t         flags_o
);
  always_comb begin
    flags_o.c = carry_i;
    flags_o.m = sum_i[DW-1];
    flags_o.l = sum_i[0];
    flags_o.z = ~|sum_i;
  end
endmodule

// File: rtl/mfx_flag_bank.sv
module mfx_flag_bank
  import mfx_pkg::*;
#(
  parameter int unsigned NGRP = 2,
  parameter int unsigned GW   = 1,
  parameter int unsigned CSRW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   upd_i,
  input  logic [GW-1:0]          grp_i,
  input  flag_t                  new_i,
  input  logic                   csr_we_i,
  input  logic [NGRP*FLAG_N-1:0] csr_wdata_i,
  output flag_t [NGRP-1:0]       flags_o,
  output logic [CSRW-1:0]        csr_rdata_o
);
  localparam int unsigned FW = NGRP * FLAG_N;

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[g] <= '0;
      end else if (csr_we_i) begin
        flags_o[g] <= csr_wdata_i[g*FLAG_N +: FLAG_N];
      end else if (upd_i && (grp_i == GW'(g))) begin
        flags_o[g] <= new_i;
      end
    end
  end

  assign csr_rdata_o = {{(CSRW-FW){1'b0}}, flags_o};
endmodule

// File: rtl/mfx_wide_adder.sv
module mfx_wide_adder
  import mfx_pkg::*;
#(
  parameter int unsigned DW   = 256,
  parameter int unsigned NGRP = 2,
  parameter int unsigned CSRW = 32,
  localparam int unsigned GW  = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned FW  = NGRP * FLAG_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [GW-1:0]   grp_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            csr_we_i,
  input  logic [CSRW-1:0] csr_wdata_i,
  output logic [CSRW-1:0] csr_rdata_o,
  output logic [DW-1:0]   result_o,
  output logic            res_valid_o
);
  flag_t [NGRP-1:0] flags;
  flag_t            new_flags;
  logic [DW-1:0]    sum;
  logic             carry;
  logic             unused_wdata;

  assign unused_wdata = ^csr_wdata_i[CSRW-1:FW];

  mfx_addsub #(.DW(DW)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_e'(op_i)),
    .cflag_i (flags[grp_i].c),
    .sum_o   (sum),
    .carry_o (carry)
  );

  mfx_flag_calc #(.DW(DW)) u_calc (
    .sum_i   (sum),
    .carry_i (carry),
    .flags_o (new_flags)
  );

  mfx_flag_bank #(.NGRP(NGRP), .GW(GW), .CSRW(CSRW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (valid_i),
    .grp_i       (grp_i),
    .new_i       (new_flags),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i[FW-1:0]),
    .flags_o     (flags),
    .csr_rdata_o (csr_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) result_o <= sum;
    end
  end
endmodule

// File: rtl/mfx_wide_adder_chk.sv
module mfx_wide_adder_chk #(
  parameter int unsigned DW   = 256,
  parameter int unsigned NGRP = 2,
  parameter int unsigned CSRW = 32,
  parameter int unsigned GW   = 1,
  parameter int unsigned FW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [GW-1:0]   grp_i,
  input logic            csr_we_i,
  input logic [FW-1:0]   csr_wdata_i,
  input logic [CSRW-1:0] csr_rdata_o,
  input logic [DW-1:0]   result_o,
  input logic            res_valid_o
);
  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[CSRW-1:FW] == '0);

  // R9 and R10: register write lands and beats a concurrent update
  p_csr_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i |=> csr_rdata_o[FW-1:0] == $past(csr_wdata_i));

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);

  p_no_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    p_idle_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!csr_we_i && (grp_i != GW'(g))) |=>
        $stable(csr_rdata_o[g*4 +: 4]));

    p_res_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !csr_we_i && (grp_i == GW'(g))) |=>
        (csr_rdata_o[g*4+1] == result_o[DW-1]) &&
        (csr_rdata_o[g*4+2] == result_o[0]) &&
        (csr_rdata_o[g*4+3] == (result_o == '0)));
  end
endmodule

bind mfx_wide_adder mfx_wide_adder_chk #(
  .DW(DW), .NGRP(NGRP), .CSRW(CSRW), .GW(GW), .FW(FW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .grp_i       (grp_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i[FW-1:0]),
  .csr_rdata_o (csr_rdata_o),
  .result_o    (result_o),
  .res_valid_o (res_valid_o)
);

// File: tb/mfx_wide_adder_test.sv
`timescale 1ns/1ps
module mfx_wide_adder_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = '0;
  logic [0:0]   grp_i = '0;
  logic [255:0] a_i = '0;
  logic [255:0] b_i = '0;
  logic         csr_we_i = 1'b0;
  logic [31:0]  csr_wdata_i = '0;
  logic [31:0]  csr_rdata_o;
  logic [255:0] result_o;
  logic         res_valid_o;

  always #2.5 clk_i = ~clk_i;

  mfx_wide_adder uut (.*);

  typedef struct {
    logic [255:0] res;
    logic [31:0]  csr;
    string        tag;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] fm = '0;
  bit         done = 1'b0;

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input logic [1:0] op, input logic g, input logic [255:0] a,
                       input logic [255:0] b, input logic we, input logic [31:0] wd,
                       input string tag);
    logic [256:0] t;
    logic         cf;
    logic [3:0]   nf;
    exp_t         e;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; grp_i = g; a_i = a; b_i = b;
    csr_we_i = we; csr_wdata_i = wd;
    cf = g ? fm[4] : fm[0];
    case (op)
      2'd0: t = {1'b0, a} + {1'b0, b};
      2'd1: t = {1'b0, a} + {1'b0, b} + {256'b0, cf};
      2'd2: t = {1'b0, a} - {1'b0, b};
      default: t = {1'b0, a} - {1'b0, b} - {256'b0, cf};
    endcase
    nf = {t[255:0] == 256'b0, t[0], t[255], t[256]};
    if (g) fm[7:4] = nf; else fm[3:0] = nf;
    if (we) fm = wd[7:0];
    e.res = t[255:0];
    e.csr = {24'b0, fm};
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; csr_we_i = 1'b0;
    end
  endtask

  task automatic csr_write(input logic [31:0] wd);
    @(negedge clk_i);
    valid_i = 1'b0; csr_we_i = 1'b1; csr_wdata_i = wd;
    fm = wd[7:0];
    @(negedge clk_i);
    csr_we_i = 1'b0;
    chk("R9 csr write", {224'b0, csr_rdata_o}, {224'b0, 24'b0, fm});
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 unexpected result: got %h expected none", result_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, result_o, e.res);
        chk({e.tag, " flags"}, {224'b0, csr_rdata_o}, {224'b0, e.csr});
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] held;
    repeat (3) @(negedge clk_i);
    chk("R1 result", result_o, '0);
    chk("R1 valid", {255'b0, res_valid_o}, '0);
    chk("R1 flags", {224'b0, csr_rdata_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags after release", {224'b0, csr_rdata_o}, '0);

    issue(2'd0, 1'b0, 256'd5, 256'd7, 1'b0, '0, "R2 add small");
    issue(2'd0, 1'b0, {256{1'b1}}, 256'd1, 1'b0, '0, "R2 R6 add wrap to zero");
    issue(2'd1, 1'b0, 256'd1, 256'd1, 1'b0, '0, "R3 addc carry-in one");
    issue(2'd2, 1'b1, 256'd10, 256'd3, 1'b0, '0, "R4 R7 sub grp1");
    issue(2'd2, 1'b1, 256'd3, 256'd10, 1'b0, '0, "R4 sub borrow");
    issue(2'd3, 1'b1, 256'd10, 256'd3, 1'b0, '0, "R5 subb borrow-in one");
    issue(2'd0, 1'b0, {1'b1, 255'b0}, {1'b1, 255'b0}, 1'b0, '0, "R6 zero from truncated");
    issue(2'd0, 1'b0, {1'b1, 255'b0}, 256'd0, 1'b0, '0, "R6 msb set");
    issue(2'd3, 1'b0, 256'd0, 256'd0, 1'b0, '0, "R5 subb zero");
    idle(2);

    csr_write(32'hFFFF_FFA5);
    chk("R8 upper bits zero", {224'b0, csr_rdata_o}, {224'b0, 32'h0000_00A5});
    issue(2'd1, 1'b1, 256'd4, 256'd4, 1'b0, '0, "R3 R7 addc grp1 after write");
    issue(2'd1, 1'b0, 256'd4, 256'd4, 1'b0, '0, "R3 addc grp0 after write");
    issue(2'd0, 1'b0, 256'd9, 256'd9, 1'b1, 32'h0000_003C, "R10 csr beats update");
    idle(1);

    held = result_o;
    idle(3);
    chk("R11 hold", result_o, held);
    chk("R11 no pulse", {255'b0, res_valid_o}, '0);

    for (int i = 0; i < 400; i++) begin
      logic [255:0] a;
      logic [255:0] b;
      a = rnd256();
      b = ($urandom % 4 == 0) ? a : rnd256();
      issue(2'($urandom), 1'($urandom), a, b, ($urandom % 8) == 0, $urandom,
            "R2 R3 R4 R5 R7 mixed");
      if ($urandom % 5 == 0) idle(1);
    end
    idle(3);
    chk("R11 queue drained", {224'b0, 32'(sb.size())}, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule